// File: doc/BRIEF.md
# Single-Wire ROM Command and Device Selection Layer

This block sits between the bit-slot engine of a single-wire slave and its memory-command layer. After each bus reset and presence pulse it collects one 8-bit ROM command from the master, least significant bit first. It then runs the exchange that the command calls for and decides whether the device becomes selected for memory commands.

The block holds a 64-bit identity, sent least significant bit first:
- bits 7..0 carry an 8-bit family code (default 2Dh);
- bits 55..8 carry a 48-bit serial number;
- bits 63..56 carry a CRC-8 of the first 56 bits.

The CRC is worked out at elaboration time from the family and serial parameters.

There are five commands:
- read identity (33h);
- match (55h);
- search (F0h), which runs the bit/complement/choice triplet;
- skip (CCh);
- resume (A5h).

A resume flag is set only when a match or search ends successfully. Resume uses that flag to reselect the device without a new identity exchange.

The block talks to the slot engine one bit at a time. It raises `req_valid` and states whether the next slot is a read slot (the device drives `req_bit`) or a write slot (the master's bit comes back on `slot_bit`). The engine answers each request with a one-cycle `slot_done`. `selected` goes to the memory layer.

Top module: `rom_select_layer`

## Requirements
- R1: While `rst` is high, `selected`, `rc_flag` and `req_valid` are 0. One cycle after a `bus_reset` pulse, `req_valid`=1, `req_read`=0 and `selected`=0.
- R2: The command is taken from 8 write slots, first slot = bit 0. Codes: 33h read identity, 55h match, F0h search, CCh skip, A5h resume.
- R3: Read identity issues 64 read slots carrying identity bits 0..63: family code 2Dh in bits 7..0, the serial number in bits 55..8 and the CRC in bits 63..56. It clears `rc_flag`, and sets `selected` one cycle after the last slot.
- R4: Identity bits 63..56 equal the CRC-8 with polynomial X8+X5+X4+1, zero start and LSB-first input, taken over bits 55..0. The same CRC run over all 64 bits ends at zero.
- R5: Match clears `rc_flag` and issues 64 write slots. If every bit equals the identity, `selected`=1 and `rc_flag`=1 one cycle after the last slot.
- R6: On the first mismatching bit of a match or a search, the block drops `req_valid` and leaves `selected` at 0 until the next `bus_reset`.
- R7: Search clears `rc_flag` and then, for each bit i = 0..63, issues three slots: a read slot with bit i, a read slot with its complement, and a write slot. After 64 matching choices, `selected`=1 and `rc_flag`=1.
- R8: A search choice bit that differs from identity bit i ends the search with no selection (as in R6).
- R9: Skip sets `selected` one cycle after the command, with no further slots, and clears `rc_flag`. While `selected`=1, `req_valid`=0.
- R10: Resume sets `selected` with no further slots when `rc_flag`=1. When `rc_flag`=0 it leaves the block idle, with no slots and no selection.
- R11: An unknown command code leaves the block idle until the next `bus_reset`, with no slots, no selection and `rc_flag` unchanged.
- R12: `bus_reset` clears `selected` but leaves `rc_flag` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_reset | input | 1 | One-cycle pulse: reset and presence finished, ROM phase starts |
| slot_done | input | 1 | One-cycle pulse: the requested slot is complete |
| slot_bit | input | 1 | Bit written by the master in a completed write slot |
| req_valid | output | 1 | A slot is requested |
| req_read | output | 1 | 1: read slot (device sends `req_bit`); 0: write slot |
| req_bit | output | 1 | Bit the device sends in a read slot |
| selected | output | 1 | Device selected for memory commands |
| rc_flag | output | 1 | Resume flag |

## Verification
Every output is a register, so each result appears exactly one clock after the edge that takes the causing pulse. That pulse is either `bus_reset` or the `slot_done` of the last command, identity or choice bit. The bench drives pulses on falling edges and samples one falling edge later. It therefore reads the new request, the selection and the resume flag exactly one cycle after the cause, and checks at that point that no further request follows where none is due. Read-slot bits are sampled in the same half cycle in which the bench answers the request, so each sent bit is compared against the bench's own identity and CRC.

// File: rtl/rom_sel_pkg.sv
package rom_sel_pkg;
  localparam int FAM_W = 8;
  localparam int SER_W = 48;
  localparam int CRC_W = 8;
  localparam int ID_W  = FAM_W + SER_W + CRC_W;
  localparam int CMD_W = 8;

  localparam logic [CMD_W-1:0] OP_READ_ID = 8'h33;
  localparam logic [CMD_W-1:0] OP_MATCH   = 8'h55;
  localparam logic [CMD_W-1:0] OP_SEARCH  = 8'hF0;
  localparam logic [CMD_W-1:0] OP_SKIP    = 8'hCC;
  localparam logic [CMD_W-1:0] OP_RESUME  = 8'hA5;

  // reflected form of X8+X5+X4+1
  localparam logic [CRC_W-1:0] CRC_POLY_REV = 8'h8C;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_READID,
    ST_MATCH,
    ST_SRCH_TRUE,
    ST_SRCH_CMPL,
    ST_SRCH_PICK,
    ST_SEL
  } rom_state_e;

  function automatic logic [CRC_W-1:0] id_crc(input logic [FAM_W+SER_W-1:0] body);
    logic [CRC_W-1:0] c;
    logic fb;
    c = '0;
    for (int i = 0; i < FAM_W + SER_W; i++) begin
      fb = c[0] ^ body[i];
      c  = c >> 1;
      if (fb) c = c ^ CRC_POLY_REV;
    end
    return c;
  endfunction
endpackage

// File: rtl/rom_id_source.sv
module rom_id_source
  import rom_sel_pkg::*;
#(
  parameter logic [FAM_W-1:0] FAMILY_CODE = 8'h2D,
  parameter logic [SER_W-1:0] SERIAL_NUM  = 48'h5A3C_0F1E_9B77
) (
  input  logic            clk,
  output logic [ID_W-1:0] id_word
);
  localparam logic [FAM_W+SER_W-1:0] BODY = {SERIAL_NUM, FAMILY_CODE};
  localparam logic [CRC_W-1:0]       CRC  = id_crc(BODY);
  localparam logic [ID_W-1:0]        IDV  = {CRC, BODY};

  // registered constant, mapped to flops
  always_ff @(posedge clk) id_word <= IDV;
endmodule

// File: rtl/rom_cmd_fsm.sv
module rom_cmd_fsm
  import rom_sel_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            bus_reset,
  input  logic            slot_done,
  input  logic            slot_bit,
  input  logic [ID_W-1:0] id_word,
  output logic            req_valid,
  output logic            req_read,
  output logic            req_bit,
  output logic            selected,
  output logic            rc_flag
);
  localparam int IDX_W = $clog2(ID_W);

  rom_state_e       state;
  logic [IDX_W-1:0] idx;
  logic [IDX_W-1:0] idx_nxt;
  logic [CMD_W-1:0] cmd_sh;
  logic [CMD_W-1:0] cmd_full;
  logic             id_last;
  logic             cmd_last;
  logic             take;

  assign idx_nxt  = idx + 1'b1;
  assign cmd_full = {slot_bit, cmd_sh[CMD_W-1:1]};
  assign id_last  = (idx == IDX_W'(ID_W - 1));
  assign cmd_last = (idx == IDX_W'(CMD_W - 1));
  assign take     = slot_done && req_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      idx       <= '0;
      cmd_sh    <= '0;
      req_valid <= 1'b0;
      req_read  <= 1'b0;
      req_bit   <= 1'b0;
      selected  <= 1'b0;
      rc_flag   <= 1'b0;
    end else if (bus_reset) begin
      state     <= ST_CMD;
      idx       <= '0;
      cmd_sh    <= '0;
      req_valid <= 1'b1;
      req_read  <= 1'b0;
      req_bit   <= 1'b0;
      selected  <= 1'b0;
    end else if (take) begin
      unique case (state)
        ST_CMD: begin
          if (!cmd_last) begin
            cmd_sh <= cmd_full;
            idx    <= idx_nxt;
          end else begin
            idx <= '0;
            case (cmd_full)
              OP_READ_ID: begin
                rc_flag  <= 1'b0;
                state    <= ST_READID;
                req_read <= 1'b1;
                req_bit  <= id_word[0];
              end
              OP_MATCH: begin
                rc_flag  <= 1'b0;
                state    <= ST_MATCH;
                req_read <= 1'b0;
              end
              OP_SEARCH: begin
                rc_flag  <= 1'b0;
                state    <= ST_SRCH_TRUE;
                req_read <= 1'b1;
                req_bit  <= id_word[0];
              end
              OP_SKIP: begin
                rc_flag   <= 1'b0;
                state     <= ST_SEL;
                selected  <= 1'b1;
                req_valid <= 1'b0;
              end
              OP_RESUME: begin
                req_valid <= 1'b0;
                if (rc_flag) begin
                  state    <= ST_SEL;
                  selected <= 1'b1;
                end else begin
                  state <= ST_IDLE;
                end
              end
              default: begin
                state     <= ST_IDLE;
                req_valid <= 1'b0;
              end
            endcase
          end
        end
        ST_READID: begin
          if (id_last) begin
            state     <= ST_SEL;
            selected  <= 1'b1;
            req_valid <= 1'b0;
            req_read  <= 1'b0;
          end else begin
            idx     <= idx_nxt;
            req_bit <= id_word[idx_nxt];
          end
        end
        ST_MATCH: begin
          if (slot_bit != id_word[idx]) begin
            state     <= ST_IDLE;
            req_valid <= 1'b0;
          end else if (id_last) begin
            state     <= ST_SEL;
            selected  <= 1'b1;
            rc_flag   <= 1'b1;
            req_valid <= 1'b0;
          end else begin
            idx <= idx_nxt;
          end
        end
        ST_SRCH_TRUE: begin
          state   <= ST_SRCH_CMPL;
          req_bit <= ~id_word[idx];
        end
        ST_SRCH_CMPL: begin
          state    <= ST_SRCH_PICK;
          req_read <= 1'b0;
          req_bit  <= 1'b0;
        end
        ST_SRCH_PICK: begin
          if (slot_bit != id_word[idx]) begin
            state     <= ST_IDLE;
            req_valid <= 1'b0;
          end else if (id_last) begin
            state     <= ST_SEL;
            selected  <= 1'b1;
            rc_flag   <= 1'b1;
            req_valid <= 1'b0;
          end else begin
            idx      <= idx_nxt;
            state    <= ST_SRCH_TRUE;
            req_read <= 1'b1;
            req_bit  <= id_word[idx_nxt];
          end
        end
        default: begin
          req_valid <= 1'b0;
        end
      endcase
    end
  end

  // R12: bus reset keeps the resume flag and drops selection
  assert_rc_kept_R12: assert property (@(posedge clk) disable iff (rst)
    bus_reset |=> (rc_flag == $past(rc_flag)) && !selected);

  // R5/R7: the resume flag only rises together with a selection
  assert_rc_with_sel_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(rc_flag) |-> selected);

  // R9: no slot requests while selected
  assert_sel_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    selected |-> !req_valid);

  // R6: idle is left only through bus_reset
  assert_idle_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && !bus_reset) |=> (state == ST_IDLE && !req_valid && !selected));

  // R7: second slot of a triplet sends the complement of the identity bit
  assert_srch_cmpl_R7: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SRCH_CMPL) |-> (req_valid && req_read && (req_bit != id_word[idx])));

  // R7: the choice slot is a write slot
  assert_srch_pick_R7: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SRCH_PICK) |-> (req_valid && !req_read));
endmodule

// File: rtl/rom_select_layer.sv
module rom_select_layer
  import rom_sel_pkg::*;
#(
  parameter logic [FAM_W-1:0] FAMILY_CODE = 8'h2D,
  parameter logic [SER_W-1:0] SERIAL_NUM  = 48'h5A3C_0F1E_9B77
) (
  input  logic clk,
  input  logic rst,
  input  logic bus_reset,
  input  logic slot_done,
  input  logic slot_bit,
  output logic req_valid,
  output logic req_read,
  output logic req_bit,
  output logic selected,
  output logic rc_flag
);
  logic [ID_W-1:0] id_word;

  rom_id_source #(
    .FAMILY_CODE(FAMILY_CODE),
    .SERIAL_NUM (SERIAL_NUM)
  ) u_id (
    .clk    (clk),
    .id_word(id_word)
  );

  rom_cmd_fsm u_fsm (
    .clk      (clk),
    .rst      (rst),
    .bus_reset(bus_reset),
    .slot_done(slot_done),
    .slot_bit (slot_bit),
    .id_word  (id_word),
    .req_valid(req_valid),
    .req_read (req_read),
    .req_bit  (req_bit),
    .selected (selected),
    .rc_flag  (rc_flag)
  );
endmodule

// File: tb/rom_select_layer_bench.sv
module rom_select_layer_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_reset = 1'b0;
  logic slot_done = 1'b0;
  logic slot_bit = 1'b0;
  logic req_valid, req_read, req_bit, selected, rc_flag;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  localparam logic [7:0]  FAM = 8'h2D;
  localparam logic [47:0] SER = 48'h5A3C_0F1E_9B77;
  logic [63:0] exp_id;

  always #2.5 clk = ~clk;

  rom_select_layer u_rom_select_layer (
    .clk(clk), .rst(rst), .bus_reset(bus_reset), .slot_done(slot_done),
    .slot_bit(slot_bit), .req_valid(req_valid), .req_read(req_read),
    .req_bit(req_bit), .selected(selected), .rc_flag(rc_flag)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: run hung, act=%0d cycles exp<=150000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  function automatic logic [7:0] crc_bits(input logic [63:0] d, input int n);
    logic [7:0] c = 8'h00;
    for (int i = 0; i < n; i++) begin
      logic fb = c[0] ^ d[i];
      c = {1'b0, c[7:1]};
      if (fb) c = c ^ 8'h8C;
    end
    return c;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic pulse_bus_reset();
    @(negedge clk) bus_reset = 1'b1;
    @(negedge clk) bus_reset = 1'b0;
  endtask

  // master write slot; returns 0 if no write request was pending
  task automatic wr_slot(input logic b, output bit ok);
    ok = req_valid && !req_read;
    if (ok) begin
      slot_bit = b; slot_done = 1'b1;
      @(negedge clk) slot_done = 1'b0;
    end
  endtask

  task automatic rd_slot(output logic b, output bit ok);
    ok = req_valid && req_read;
    b  = req_bit;
    if (ok) begin
      slot_done = 1'b1;
      @(negedge clk) slot_done = 1'b0;
    end
  endtask

  task automatic send_cmd(input logic [7:0] c, input string tag);
    bit ok;
    bit all_ok = 1'b1;
    for (int i = 0; i < 8; i++) begin
      wr_slot(c[i], ok);
      all_ok &= ok;
    end
    chk(all_ok, {tag, " command write slots"}, all_ok, 1);
  endtask

  task automatic t_reset_R1();
    chk(!selected && !rc_flag && !req_valid, "R1 reset state",
        {selected, rc_flag, req_valid}, 0);
    @(negedge clk) rst = 1'b0;
    pulse_bus_reset();
    chk(req_valid && !req_read && !selected, "R1 after bus_reset",
        {req_valid, req_read, selected}, 3'b100);
  endtask

  task automatic t_read_id_R3();
    logic [63:0] got = '0;
    logic b;
    bit ok;
    bit all_ok = 1'b1;
    send_cmd(8'h33, "R2 R3");
    for (int i = 0; i < 64; i++) begin
      rd_slot(b, ok);
      all_ok &= ok;
      got[i] = b;
    end
    chk(all_ok, "R3 read slots present", all_ok, 1);
    chk(got == exp_id, "R3 identity bits", got, exp_id);
    chk(got[7:0] == 8'h2D, "R3 family code", got[7:0], 8'h2D);
    chk(got[63:56] == crc_bits(got, 56), "R4 crc byte", got[63:56], crc_bits(got, 56));
    chk(crc_bits(got, 64) == 8'h00, "R4 crc residue", crc_bits(got, 64), 0);
    chk(selected && !rc_flag && !req_valid, "R3 selected after 64",
        {selected, rc_flag, req_valid}, 3'b100);
  endtask

  task automatic t_match_R5(input int bad_bit);
    bit ok;
    bit all_ok = 1'b1;
    pulse_bus_reset();
    send_cmd(8'h55, "R5");
    for (int i = 0; i < 64; i++) begin
      logic b = (i == bad_bit) ? ~exp_id[i] : exp_id[i];
      wr_slot(b, ok);
      if (i == bad_bit) break;
      all_ok &= ok;
    end
    if (bad_bit < 0) begin
      chk(all_ok, "R5 match slots", all_ok, 1);
      chk(selected && rc_flag && !req_valid, "R5 full match",
          {selected, rc_flag, req_valid}, 3'b110);
    end else begin
      chk(!selected && !req_valid && !rc_flag, "R6 match mismatch idle",
          {selected, req_valid, rc_flag}, 0);
      repeat (5) @(negedge clk);
      chk(!selected && !req_valid, "R6 stays idle", {selected, req_valid}, 0);
    end
  endtask

  task automatic t_resume_R10(input logic exp_sel);
    pulse_bus_reset();
    chk(!selected, "R12 bus_reset clears selected", selected, 0);
    chk(rc_flag == exp_sel, "R12 rc kept over bus_reset", rc_flag, exp_sel);
    send_cmd(8'hA5, "R10");
    chk(selected == exp_sel && !req_valid, "R10 resume outcome",
        {selected, req_valid}, {exp_sel, 1'b0});
  endtask

  task automatic t_search_R7(input int bad_bit);
    logic t, c;
    bit ok1, ok2, ok3;
    bit all_ok = 1'b1;
    bit bits_ok = 1'b1;
    pulse_bus_reset();
    send_cmd(8'hF0, "R7");
    for (int i = 0; i < 64; i++) begin
      logic pick = (i == bad_bit) ? ~exp_id[i] : exp_id[i];
      rd_slot(t, ok1);
      rd_slot(c, ok2);
      wr_slot(pick, ok3);
      all_ok  &= ok1 & ok2 & ok3;
      bits_ok &= (t == exp_id[i]) && (c == ~exp_id[i]);
      if (i == bad_bit) break;
    end
    chk(all_ok, "R7 triplet slot kinds", all_ok, 1);
    chk(bits_ok, "R7 true and complement bits", bits_ok, 1);
    if (bad_bit < 0)
      chk(selected && rc_flag && !req_valid, "R7 search complete",
          {selected, rc_flag, req_valid}, 3'b110);
    else
      chk(!selected && !req_valid && !rc_flag, "R8 search dropout",
          {selected, req_valid, rc_flag}, 0);
  endtask

  task automatic t_skip_R9();
    pulse_bus_reset();
    send_cmd(8'hCC, "R9");
    chk(selected && !req_valid && !rc_flag, "R9 skip selects",
        {selected, req_valid, rc_flag}, 3'b100);
  endtask

  task automatic t_unknown_R11();
    pulse_bus_reset();
    send_cmd(8'h99, "R11");
    chk(!selected && !req_valid && rc_flag, "R11 unknown idles, rc kept",
        {selected, req_valid, rc_flag}, 3'b001);
    repeat (4) @(negedge clk);
    chk(!selected && !req_valid, "R11 stays idle", {selected, req_valid}, 0);
  endtask

  initial begin
    exp_id = {crc_bits({8'h00, SER, FAM}, 56), SER, FAM};
    repeat (3) @(negedge clk);
    t_reset_R1();
    t_read_id_R3();
    t_match_R5(-1);
    t_resume_R10(1'b1);
    t_match_R5(20);
    t_resume_R10(1'b0);
    t_search_R7(-1);
    t_unknown_R11();
    t_search_R7(5);
    t_skip_R9();
    t_resume_R10(1'b0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule